// File: doc/BRIEF.md
# Cascade Parallel Bus Token Node

This block is one node on a shared 16-bit parallel bus. The bus passes partial results between one master and up to six slaves. Two active-low flags per side hand the right to drive from node to node. The master opens a round when its local logic requests a turn. Its second output flag hands the token to the first slave, and each slave's first output flag hands it to the next slave. The last slave's first output flag closes the round at the master. A node whose turn has come drives its word for a fixed window and pulses its strobe flag partway through that window. The receivers capture the bus on the falling edge of that strobe. How the words are computed and combined is outside this block.

The node runs on a clock that is `TICKS` times faster than the system's master clock. This lets the half-period strobe be built from whole cycles. The flag inputs are asynchronous to the node. They pass through a `SYNC_STAGES` synchronizer. The bus data goes through a delay line of the same depth, so the word that is captured is the one that was on the bus when the falling flag was first sampled.

The bus pins are split into data in, data out and a drive enable. The enable low stands for high impedance. A single-node system loops its second output flag back to its own first input flag and ties its second input flag high. Turns of adjacent nodes do not overlap as long as `2*TICKS <= TICKS+SYNC_STAGES+1`.

Top module: `cascade_bus_node`

## Requirements
- R1: While `rst_ni` is low, `bus_drv_o` is 0, `flag_a_o` and `flag_b_o` are both 1, and `rx_valid_o` is 0.
- R2: In the master role (`slave_sel_i`=0), `launch_i` high at a clock edge while the node is idle starts a turn. From that edge on, the node drives the `tx_word_i` value sampled at that edge, with `bus_drv_o`=1, for 2*TICKS cycles.
- R3: During a turn the strobe is low for TICKS/2 cycles, starting TICKS cycles after the drive starts. A master pulses both `flag_a_o` and `flag_b_o`. A slave pulses only `flag_a_o` and holds `flag_b_o` at 1. Outside a turn both flags are 1.
- R4: In the slave role (`slave_sel_i`=1), if `flag_b_i` is first sampled low at edge n (after being high), a turn starts at edge n+SYNC_STAGES.
- R5: If `flag_a_i` is first sampled low at edge n (after being high), then after edge n+SYNC_STAGES `rx_valid_o` is 1 for exactly one cycle. At the same time `rx_word_o` holds the `bus_dat_i` value sampled at edge n.
- R6: A slave ignores `launch_i`, and a master ignores `flag_b_i`.
- R7: A start request that arrives while a turn is in progress is ignored. It neither extends nor restarts the turn.
- R8: `sleep_i` high at an edge ends any turn and clears the synchronizers. While it stays high: drive is 0, both flags are 1, `rx_valid_o` is 0, and start requests are ignored.
- R9: In a master plus six slaves chain with TICKS=2 and SYNC_STAGES=2, node k (master k=0) drives during cycles 5k to 5k+3 after the launch edge. At most one node drives in any cycle. Every slave receives the master's word at cycle 5, and the master receives the last slave's word at cycle 35.
- R10: A single master with its `flag_b_o` looped back to its own `flag_a_i` captures its own word SYNC_STAGES+TICKS+1 cycles after launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Node clock, TICKS times the master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Power-down hold, active high |
| slave_sel_i | input | 1 | Role: 0 is master or single node, 1 is slave |
| launch_i | input | 1 | Master turn request |
| tx_word_i | input | DATA_W | Word to drive on this node's turn |
| flag_a_i | input | 1 | Capture strobe in, active low |
| flag_b_i | input | 1 | Token in for a slave, active low |
| bus_dat_i | input | DATA_W | Resolved bus value, bit 15 is the MSB |
| bus_dat_o | output | DATA_W | Word driven by this node (0 when idle) |
| bus_drv_o | output | 1 | Drive enable; 0 means high impedance |
| flag_a_o | output | 1 | Strobe and next-token out, active low |
| flag_b_o | output | 1 | Master token out to the first slave, active low |
| rx_word_o | output | DATA_W | Last captured word |
| rx_valid_o | output | 1 | One-cycle capture pulse |

## Verification
The assertions assume that `slave_sel_i` is fixed for the life of a node. They also assume that a falling input flag stays low long enough to be sampled, and that each node sees a bus that no other node drives during its own window. The bench wires a real master and six slaves in the prescribed chain with the role pins tied, so every flag edge comes from a neighbour's strobe logic. The requests that should be ignored (slave launch, master token, relaunch while busy, launch during sleep) are issued from separate bench signals while the chain is idle or while the node under test is in its turn. Their absence of effect is then read from the drive enables, flags and capture pulses.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/cbus_sync_fall.sv
module cbus_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flag_i,
  output logic fall_o
);
  // idle-high flags: shift chain rests at all ones
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '1;
    else if (clr_i) sh_q <= '1;
    else            sh_q <= {sh_q[STAGES-1:0], flag_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/cbus_delay.sv
module cbus_delay #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] dat_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= dat_i;
      for (int j = 1; j < STAGES; j++) stg_q[j] <= stg_q[j-1];
    end
  end

  assign dat_o = stg_q[STAGES-1];
endmodule

// File: rtl/cbus_turn.sv
module cbus_turn #(
  parameter int unsigned W     = 16,
  parameter int unsigned TICKS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         drv_o,
  output logic [W-1:0] dat_o,
  output logic         strobe_o
);
  localparam int unsigned WIN       = 2 * TICKS;
  localparam int unsigned CNT_W     = (WIN > 2) ? $clog2(WIN) : 1;
  localparam int unsigned PULSE_END = TICKS + TICKS / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      word_q <= word_i;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drv_o    = busy_q;
  assign dat_o    = busy_q ? word_q : '0;
  assign strobe_o = busy_q && (int'(cnt_q) >= int'(TICKS)) && (int'(cnt_q) < int'(PULSE_END));
endmodule

// File: rtl/cascade_bus_node.sv
module cascade_bus_node
  import cbus_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TICKS       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              slave_sel_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              flag_a_i,
  input  logic              flag_b_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              bus_drv_o,
  output logic              flag_a_o,
  output logic              flag_b_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  role_e             role;
  logic              fall_a, fall_b, start, strobe;
  logic [DATA_W-1:0] dly_dat;

  assign role = role_e'(slave_sel_i);

  cbus_sync_fall #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk_i, .rst_ni, .clr_i(sleep_i), .flag_i(flag_a_i), .fall_o(fall_a)
  );

  cbus_sync_fall #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk_i, .rst_ni, .clr_i(sleep_i), .flag_i(flag_b_i), .fall_o(fall_b)
  );

  // data delayed to match the flag synchronizer depth
  cbus_delay #(.STAGES(SYNC_STAGES), .W(DATA_W)) u_dly (
    .clk_i, .rst_ni, .dat_i(bus_dat_i), .dat_o(dly_dat)
  );

  assign start = (role == ROLE_MASTER) ? launch_i : fall_b;

  cbus_turn #(.W(DATA_W), .TICKS(TICKS)) u_turn (
    .clk_i, .rst_ni, .clr_i(sleep_i), .start_i(start), .word_i(tx_word_i),
    .drv_o(bus_drv_o), .dat_o(bus_dat_o), .strobe_o(strobe)
  );

  assign flag_a_o = ~strobe;
  assign flag_b_o = ~(strobe && (role == ROLE_MASTER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (sleep_i) begin
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= fall_a;
      if (fall_a) rx_word_o <= dly_dat;
    end
  end
endmodule

// File: rtl/cbus_node_chk.sv
module cbus_node_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              slave_sel_i,
  input logic              launch_i,
  input logic [DATA_W-1:0] bus_dat_o,
  input logic              bus_drv_o,
  input logic              flag_a_o,
  input logic              flag_b_o,
  input logic              rx_valid_o
);
  // R8
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!bus_drv_o && flag_a_o && flag_b_o && !rx_valid_o));

  // R3
  slave_fb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_sel_i |-> flag_b_o);

  // R3
  strobe_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_a_o |-> bus_drv_o);

  // R5
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R2
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drv_o && $past(bus_drv_o)) |-> $stable(bus_dat_o));

  // R2
  master_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !slave_sel_i && launch_i && !bus_drv_o) |=> bus_drv_o);
endmodule

bind cascade_bus_node cbus_node_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .slave_sel_i(slave_sel_i),
  .launch_i(launch_i), .bus_dat_o(bus_dat_o), .bus_drv_o(bus_drv_o),
  .flag_a_o(flag_a_o), .flag_b_o(flag_b_o), .rx_valid_o(rx_valid_o)
);

// File: tb/tb_cascade_bus_node.sv
module tb_cascade_bus_node;
  localparam int W = 16, T = 2, S = 2, NS = 6;
  localparam int HOP = T + S + 1, WIN = 2 * T;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, launch, slv_launch, mfb_in, s_sleep, s_launch;
  logic [W-1:0] word [0:NS];
  logic [W-1:0] s_word;
  logic [W-1:0] dat [0:NS];
  logic [W-1:0] rw  [0:NS];
  logic [NS:0]  drv, fa, fb, rv;
  logic [W-1:0] bus;
  int           ndrv;
  logic [W-1:0] s_dat, s_rw, s_bus;
  logic         s_drv, s_fa, s_fb, s_rv;
  int total = 0, bad = 0;
  bit done = 0;

  always_comb begin
    bus = '0; ndrv = 0;
    for (int k = 0; k <= NS; k++) if (drv[k]) begin bus |= dat[k]; ndrv++; end
  end
  assign s_bus = s_drv ? s_dat : '0;

  cascade_bus_node #(.DATA_W(W), .TICKS(T), .SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(1'b0), .slave_sel_i(1'b0), .launch_i(launch),
    .tx_word_i(word[0]), .flag_a_i(fa[NS]), .flag_b_i(mfb_in), .bus_dat_i(bus),
    .bus_dat_o(dat[0]), .bus_drv_o(drv[0]), .flag_a_o(fa[0]), .flag_b_o(fb[0]),
    .rx_word_o(rw[0]), .rx_valid_o(rv[0]));

  for (genvar k = 1; k <= NS; k++) begin : g_slv
    cascade_bus_node #(.DATA_W(W), .TICKS(T), .SYNC_STAGES(S)) u_slv (
      .clk_i(clk), .rst_ni(rst_n), .sleep_i(1'b0), .slave_sel_i(1'b1), .launch_i(slv_launch),
      .tx_word_i(word[k]), .flag_a_i(fa[0]), .flag_b_i((k == 1) ? fb[0] : fa[k-1]),
      .bus_dat_i(bus), .bus_dat_o(dat[k]), .bus_drv_o(drv[k]), .flag_a_o(fa[k]),
      .flag_b_o(fb[k]), .rx_word_o(rw[k]), .rx_valid_o(rv[k]));
  end

  cascade_bus_node #(.DATA_W(W), .TICKS(T), .SYNC_STAGES(S)) u_single (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(s_sleep), .slave_sel_i(1'b0), .launch_i(s_launch),
    .tx_word_i(s_word), .flag_a_i(s_fb), .flag_b_i(1'b1), .bus_dat_i(s_bus),
    .bus_dat_o(s_dat), .bus_drv_o(s_drv), .flag_a_o(s_fa), .flag_b_o(s_fb),
    .rx_word_o(s_rw), .rx_valid_o(s_rv));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural model of one chain round, compared every cycle
  task automatic chain_round();
    @(negedge clk); launch = 1'b1;
    for (int t = 0; t <= 7 * HOP + 2; t++) begin
      int own;
      logic [W-1:0] eb;
      logic [NS:0] ed, efa, efb, erv;
      @(negedge clk); launch = 1'b0;
      own = ((t % HOP) < WIN && (t / HOP) <= NS) ? t / HOP : -1;
      eb = (own >= 0) ? word[own] : '0;
      ed = '0; efa = '1; efb = '1; erv = '0;
      if (own >= 0) ed[own] = 1'b1;
      for (int k = 0; k <= NS; k++)
        if (t >= k * HOP + T && t < k * HOP + T + T / 2) efa[k] = 1'b0;
      if (t >= T && t < T + T / 2) efb[0] = 1'b0;
      if (t == HOP) erv[NS:1] = '1;
      if (t == 7 * HOP) erv[0] = 1'b1;
      chk(ndrv <= 1 && bus == eb, "R9 bus owner", {32'(ndrv), 16'(0), bus}, {32'(1), 16'(0), eb});
      chk(drv == ed, "R2 R4 drive", drv, ed);
      chk(fa == efa, "R3 flag_a", fa, efa);
      chk(fb == efb, "R3 flag_b", fb, efb);
      chk(rv == erv, "R5 rx_valid", rv, erv);
      if (t == HOP)
        for (int k = 1; k <= NS; k++) chk(rw[k] == word[0], "R5 slave rx word", rw[k], word[0]);
      if (t == 7 * HOP) chk(rw[0] == word[NS], "R9 master rx word", rw[0], word[NS]);
    end
  endtask

  task automatic single_round(input bit relaunch);
    @(negedge clk); s_launch = 1'b1;
    for (int t = 0; t <= HOP + 3; t++) begin
      @(negedge clk);
      s_launch = (relaunch && t == 1) ? 1'b1 : 1'b0;
      chk(s_drv == (t < WIN), relaunch ? "R7 relaunch drive" : "R10 drive", s_drv, (t < WIN));
      chk(s_rv == (t == HOP), relaunch ? "R7 single capture" : "R10 capture", s_rv, (t == HOP));
      if (t == HOP) chk(s_rw == s_word, "R10 own word", s_rw, s_word);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; launch = 0; slv_launch = 0; mfb_in = 1; s_sleep = 0; s_launch = 0;
    s_word = 16'h0;
    for (int k = 0; k <= NS; k++) word[k] = 16'(16'h1111 * (k + 1));
    repeat (3) @(negedge clk);
    // R1
    chk(drv == '0 && !s_drv, "R1 reset drive", {drv, s_drv}, 0);
    chk(fa == '1 && fb == '1 && s_fa && s_fb, "R1 reset flags", {fa, fb}, {8'h7f, 7'h7f});
    chk(rv == '0 && !s_rv, "R1 reset rx_valid", {rv, s_rv}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chain_round();
    word[0] = 16'h8000; word[NS] = 16'hFFFF; word[3] = 16'h0001;
    chain_round();
    for (int k = 0; k <= NS; k++) word[k] = 16'(16'h0001 << (k * 2));
    chain_round();

    s_word = 16'hA5C3; single_round(1'b0);
    s_word = 16'h3C5A; single_round(1'b1);

    // R6: slave launch ignored, master token input ignored
    @(negedge clk); slv_launch = 1'b1;
    @(negedge clk); slv_launch = 1'b0;
    for (int t = 0; t < HOP + 2; t++) begin
      @(negedge clk);
      chk(drv == '0, "R6 slave launch", drv, 0);
    end
    mfb_in = 1'b0;
    @(negedge clk); @(negedge clk); mfb_in = 1'b1;
    for (int t = 0; t < HOP + 3; t++) begin
      @(negedge clk);
      chk(drv == '0 && rv == '0, "R6 master flag_b", {drv, rv}, 0);
    end

    // R8: sleep aborts a turn and holds the node idle
    s_word = 16'h7E7E;
    @(negedge clk); s_launch = 1'b1;
    @(negedge clk); s_launch = 1'b0;
    @(negedge clk); s_sleep = 1'b1;
    @(negedge clk);
    chk(!s_drv && s_fa && s_fb && !s_rv, "R8 sleep abort", {s_drv, s_fa, s_fb, s_rv}, 4'b0110);
    s_launch = 1'b1;
    @(negedge clk);
    chk(!s_drv, "R8 launch in sleep", s_drv, 0);
    s_launch = 1'b0; s_sleep = 1'b0;
    for (int t = 0; t < HOP + 3; t++) begin
      @(negedge clk);
      chk(!s_drv && !s_rv, "R8 after sleep", {s_drv, s_rv}, 0);
    end

    word[0] = 16'hBEEF; word[NS] = 16'hCAFE;
    chain_round();

    done = 1;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule